// File: doc/BRIEF.md
# Self-Routing Tag Rotation Unit

This block sits on one input port of a cell switch element. A cell's 32-bit routing tag arrives as eight 4-bit nibbles on consecutive cycles. The first nibble comes in the cycle that carries the start-of-cell strobe. The block works out how many leading tag bits this stage needs to choose an output gang. That count depends on a static gang-size setting. The block then reads those bits as the gang index. It sends the tag on downstream with the consumed bits moved from the head to the tail.

Because the bits are rotated and not dropped, each later stage finds its own routing bits at the head of the tag. The tag's parity also survives unchanged. When every output port forms a single gang, the stage spreads traffic itself. In that mode no bits are consumed and the tag leaves the block exactly as it came in.

The block holds the whole tag before emitting anything, so the output trails the input by a fixed eight cycles. The gang index and the mode flag are held steady while the rotated tag is being sent.

Top module: `tag_rotator`

## Requirements
- R1: After reset, `out_valid` and `out_first` are 0 until a complete tag has been captured.
- R2: A cell's tag is captured as TAG_0 in the cycle where `soc_in` is 1, followed by TAG_1 to TAG_7 on the next seven cycles. Bit 3 of TAG_0 is the head of the tag, so the tag reads as the 32-bit word {TAG_0, ..., TAG_7}.
- R3: The first rotated nibble appears exactly eight cycles after TAG_0 is presented. `out_valid` then stays 1 for eight consecutive cycles, and `out_first` is 1 on the first of them only. Nibbles leave in head-to-tail order.
- R4: `gang_log2` = g in 0..5 selects a gang size of 2^g ports. That gives 32/2^g gangs and consumes k = 5 - g routing bits. Values 6 and 7 act like 5.
- R5: `gang_idx` holds the first k bits of the tag, the first bit in the most significant position, right-aligned. It is held during the whole emission.
- R6: The emitted 32-bit tag is the captured tag rotated left by k bits: the head bits reappear after TAG_7. Rotating the emitted tag left by 32 - k restores the captured tag.
- R7: With k = 0 (distribution), `dist_mode` is 1, `gang_idx` is 0 and the tag is emitted unchanged. Otherwise `dist_mode` is 0.
- R8: The emitted tag has the same parity as the captured tag.
- R9: A `soc_in` pulse before a tag is complete discards the partial tag, and capture restarts with that cycle's nibble as TAG_0. A discarded tag produces no output.
- R10: A new cell may start in the cycle right after the previous TAG_7. Its rotated tag follows the previous one with no gap.
- R11: Nibbles that arrive while no tag is being captured (no preceding `soc_in`) are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gang_log2 | input | 3 | log2 of the gang size; static while cells are in flight |
| soc_in | input | 1 | Start-of-cell strobe, marks TAG_0 |
| nib_in | input | 4 | Incoming tag nibble |
| nib_out | output | 4 | Rotated tag nibble |
| out_valid | output | 1 | `nib_out` carries a tag nibble |
| out_first | output | 1 | First nibble of a rotated tag |
| gang_idx | output | 5 | Selected output gang, valid while `out_valid` is 1 |
| dist_mode | output | 1 | Distribution mode, no bits consumed |

## Verification
The assertions assume that `gang_log2` holds steady from the start of a cell until its last rotated nibble has left. They also assume that `soc_in` marks only the first nibble of a cell. The capture-count and restart properties depend on this framing. The stimulus changes the gang setting only after long idle gaps, once the output has drained. It sweeps all eight setting codes with back-to-back cells, cells with idle gaps and cells aborted by an early strobe. The idle-gap nibbles are driven with the strobe low.

// File: rtl/tagrot_pkg.sv
package tagrot_pkg;

  localparam int DEF_NIB_W  = 4;
  localparam int DEF_NIBS   = 8;
  localparam int DEF_PORTS  = 32;

  // Number of head bits a stage consumes for a gang size of 2^g ports.
  function automatic int route_bits(input int log_ports, input int g);
    if (g >= log_ports) return 0;
    return log_ports - g;
  endfunction

endpackage

// File: rtl/tagrot_capture.sv
module tagrot_capture #(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 8,
  localparam int TAG_W  = NIB_W * NIB_CNT,
  localparam int CNT_W  = $clog2(NIB_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soc_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             tag_done,
  output logic [TAG_W-1:0] tag_full
);

  logic [TAG_W-1:0] cap_reg;
  logic [CNT_W-1:0] cap_cnt;
  logic             busy;
  logic             last_nib;

  assign last_nib = busy && !soc_in && (cap_cnt == CNT_W'(NIB_CNT - 1));
  assign tag_done = last_nib;
  assign tag_full = {cap_reg[TAG_W-NIB_W-1:0], nib_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_reg <= '0;
      cap_cnt <= '0;
      busy    <= 1'b0;
    end else if (soc_in) begin
      cap_reg <= {cap_reg[TAG_W-NIB_W-1:0], nib_in};
      cap_cnt <= CNT_W'(1);
      busy    <= 1'b1;
    end else if (busy) begin
      cap_reg <= {cap_reg[TAG_W-NIB_W-1:0], nib_in};
      if (last_nib) begin
        cap_cnt <= '0;
        busy    <= 1'b0;
      end else begin
        cap_cnt <= cap_cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cap_cnt != '0)); // R2

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    soc_in |=> (busy && cap_cnt == CNT_W'(1))); // R9

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !soc_in) |=> !busy); // R11

endmodule

// File: rtl/tagrot_emitter.sv
module tagrot_emitter #(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 8,
  parameter int GI_W    = 5,
  localparam int TAG_W  = NIB_W * NIB_CNT,
  localparam int REM_W  = $clog2(NIB_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [GI_W-1:0]  load_gi,
  input  logic             load_dist,
  input  logic             load_par,
  output logic [NIB_W-1:0] nib_out,
  output logic             out_valid,
  output logic             out_first,
  output logic [GI_W-1:0]  gang_idx,
  output logic             dist_mode
);

  logic [TAG_W-1:0] sh_reg;
  logic [REM_W-1:0] rem;
  logic             first_q;
  logic             par_acc;
  logic             ref_par;
  logic             out_last;

  assign nib_out   = sh_reg[TAG_W-1 -: NIB_W];
  assign out_valid = (rem != '0);
  assign out_first = first_q;
  assign out_last  = (rem == REM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_reg    <= '0;
      rem       <= '0;
      first_q   <= 1'b0;
      gang_idx  <= '0;
      dist_mode <= 1'b0;
      par_acc   <= 1'b0;
      ref_par   <= 1'b0;
    end else if (load) begin
      sh_reg    <= load_tag;
      rem       <= REM_W'(NIB_CNT);
      first_q   <= 1'b1;
      gang_idx  <= load_gi;
      dist_mode <= load_dist;
      par_acc   <= 1'b0;
      ref_par   <= load_par;
    end else if (rem != '0) begin
      sh_reg  <= sh_reg << NIB_W;
      rem     <= rem - REM_W'(1);
      first_q <= 1'b0;
      par_acc <= par_acc ^ (^nib_out);
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (rem <= REM_W'(1))); // R10

  AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid); // R3

  AST_PARITY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> ((par_acc ^ (^nib_out)) == ref_par)); // R8

endmodule

// File: rtl/tag_rotator.sv
module tag_rotator
  import tagrot_pkg::*;
#(
  parameter int NIB_W     = DEF_NIB_W,
  parameter int NIB_CNT   = DEF_NIBS,
  parameter int PORTS     = DEF_PORTS,
  localparam int TAG_W    = NIB_W * NIB_CNT,
  localparam int LOG_PORTS = $clog2(PORTS),
  localparam int GL_W     = $clog2(LOG_PORTS + 1),
  localparam int GI_W     = (LOG_PORTS > 0) ? LOG_PORTS : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GL_W-1:0]  gang_log2,
  input  logic             soc_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic [NIB_W-1:0] nib_out,
  output logic             out_valid,
  output logic             out_first,
  output logic [GI_W-1:0]  gang_idx,
  output logic             dist_mode
);

  // Left rotation by k: head bits wrap round to the tail.
  function automatic logic [TAG_W-1:0] rot_left(input logic [TAG_W-1:0] t, input int k);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = 0; i < TAG_W; i++) r[i] = t[(i - k + TAG_W) % TAG_W];
    return r;
  endfunction

  // Top k bits of the tag, right-aligned, first bit most significant.
  function automatic logic [GI_W-1:0] head_value(input logic [TAG_W-1:0] t, input int k);
    logic [GI_W-1:0] v;
    v = '0;
    for (int j = 0; j < GI_W; j++) if (j < k) v[j] = t[TAG_W - k + j];
    return v;
  endfunction

  logic             tag_done;
  logic [TAG_W-1:0] tag_full;
  logic [TAG_W-1:0] tag_rot;
  logic [GI_W-1:0]  gi_sel;
  logic             dist_sel;
  int               nbits;

  tagrot_capture #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .soc_in   (soc_in),
    .nib_in   (nib_in),
    .tag_done (tag_done),
    .tag_full (tag_full)
  );

  always_comb begin
    nbits    = route_bits(LOG_PORTS, int'(gang_log2));
    tag_rot  = rot_left(tag_full, nbits);
    gi_sel   = head_value(tag_full, nbits);
    dist_sel = (nbits == 0);
  end

  tagrot_emitter #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT), .GI_W(GI_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tag_done),
    .load_tag  (tag_rot),
    .load_gi   (gi_sel),
    .load_dist (dist_sel),
    .load_par  (^tag_full),
    .nib_out   (nib_out),
    .out_valid (out_valid),
    .out_first (out_first),
    .gang_idx  (gang_idx),
    .dist_mode (dist_mode)
  );

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    tag_done |=> out_first); // R3

  AST_FIRST_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid); // R3

  AST_DIST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dist_mode) |-> (gang_idx == '0)); // R7

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first && !$past(tag_done)) |-> $stable(gang_idx)); // R5

endmodule

// File: tb/tb_tag_rotator.sv
module tb_tag_rotator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] gsel;
  logic       soc;
  logic [3:0] nib;
  logic [3:0] nib_out;
  logic       out_valid;
  logic       out_first;
  logic [4:0] gang_idx;
  logic       dist_mode;

  always #5 clk = ~clk;

  tag_rotator dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .gang_log2 (gsel),
    .soc_in    (soc),
    .nib_in    (nib),
    .nib_out   (nib_out),
    .out_valid (out_valid),
    .out_first (out_first),
    .gang_idx  (gang_idx),
    .dist_mode (dist_mode)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;

  logic [31:0] exp_q[$];
  int          k_q[$];
  int          t0_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nbits(input int g);
    return (g >= 5) ? 0 : 5 - g;
  endfunction

  // Head-indexed rotation: output head position i takes input head position i+k.
  function automatic logic [31:0] rot_head(input logic [31:0] t, input int k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31 - i] = t[31 - ((i + k) % 32)];
    return r;
  endfunction

  function automatic int head_num(input logic [31:0] t, input int k);
    int acc = 0;
    for (int i = 0; i < k; i++) acc = acc * 2 + int'(t[31 - i]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Receive side
  logic [31:0] rx;
  int          rx_n = 0;
  logic [4:0]  rx_gi;
  logic        rx_dist;
  bit          first_ok;
  int          rx_t;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rx_n == 0) begin
        rx_gi    = gang_idx;
        rx_dist  = dist_mode;
        first_ok = (out_first == 1'b1);
        rx_t     = cyc;
      end else begin
        if (out_first) first_ok = 1'b0;
        if (gang_idx != rx_gi) first_ok = 1'b0;
      end
      rx = {rx[27:0], nib_out};
      rx_n++;
      if (rx_n == 8) begin
        rx_n = 0;
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected output tag", rx, 32'h0);
        end else begin
          logic [31:0] src;
          int k;
          int t0;
          src = exp_q.pop_front();
          k   = k_q.pop_front();
          t0  = t0_q.pop_front();
          check(rx == rot_head(src, k), "R6", "rotated tag", rx, rot_head(src, k));
          check(rot_head(rx, (32 - k) % 32) == src, "R6", "inverse rotation", rot_head(rx, (32 - k) % 32), src);
          check(int'(rx_gi) == head_num(src, k), "R5", "gang index", 32'(rx_gi), 32'(head_num(src, k)));
          check(rx_dist == (k == 0), "R7", "distribution flag", 32'(rx_dist), 32'(k == 0));
          if (k == 0) check(rx == src, "R7", "unchanged tag", rx, src);
          check($countones(rx) % 2 == $countones(src) % 2, "R8", "parity",
                32'($countones(rx) % 2), 32'($countones(src) % 2));
          check(first_ok, "R3", "first flag or held index", 32'(first_ok), 32'h1);
          check(rx_t == t0 + 8, "R3", "latency cycle", 32'(rx_t - t0), 32'd8);
        end
      end
    end
  end

  // Drive side
  task automatic send_cell(input logic [31:0] tag);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      soc = (j == 0);
      nib = tag[31 - 4*j -: 4];
      if (j == 0) begin
        exp_q.push_back(tag);
        k_q.push_back(nbits(int'(gsel)));
        t0_q.push_back(cyc);
      end
    end
    sent++;
  endtask

  task automatic send_partial(input logic [31:0] tag, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      soc = (j == 0);
      nib = tag[31 - 4*j -: 4];
    end
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      soc = 1'b0;
      nib = 4'(j * 7 + 3);
    end
  endtask

  function automatic logic [31:0] mk_tag(input int g, input int n);
    case (n)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0001;
      default: return (32'h9E37_79B9 * 32'(n + 3 * g + 1)) ^ 32'(g << 13);
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    soc   = 1'b0;
    nib   = 4'h0;
    gsel  = 3'd0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    // R11: stray nibbles with no strobe before any cell
    idle(12);
    check(out_valid == 1'b0 && out_first == 1'b0, "R1", "quiet after reset", 32'(out_valid), 32'h0);

    // R4 sweep of every setting code, back-to-back (R10) and gapped cells
    for (int g = 0; g < 8; g++) begin
      gsel = 3'(g);
      idle(2);
      for (int n = 0; n < 7; n++) begin
        send_cell(mk_tag(g, n));
        if (n % 3 == 2) idle(n);
      end
      idle(14);
    end

    // R9: aborted captures
    gsel = 3'd2;
    idle(2);
    send_partial(32'hDEAD_BEEF, 3);
    send_cell(32'h1357_9BDF);
    send_partial(32'hCAFE_F00D, 7);
    send_cell(32'h2468_ACE0);
    idle(14);

    check(exp_q.size() == 0, "R9", "pending tags", 32'(exp_q.size()), 32'h0);
    check(got == sent, "R11", "tag count", 32'(got), 32'(sent));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual %0d expected %0d", got, sent);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule